// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit chooses the address of the next instruction for a 32-bit core whose instructions are all four bytes long. It receives the current program counter, the decoded major opcode, the second register-select field, the values of both source registers, the 16-bit immediate and the 26-bit jump index. It returns the next program counter and a flag that is high when control flow leaves the sequential path.

Three kinds of transfer are resolved. An unconditional jump keeps the top four bits of the sequential address and takes the rest from the index. Two equality branches compare the register values with each other. Four sign tests compare the first register value with zero. Branch targets are PC-relative and counted in words from the instruction that follows. Every other opcode falls through to the sequential address. The unit sits between decode and fetch, and its outputs settle in the same cycle as its inputs.

Top module: `npc_unit`

## Requirements
- R1: An opcode other than 1, 2, 4, 5, 6 or 7 leaves `taken_o` low and gives `next_pc_o` equal to the sequential address, `{pc_i[31:2]+1, 2'b00}`.
- R2: Opcode 2 is an unconditional jump. `taken_o` is high and `next_pc_o` is `{seq[31:28], jidx_i, 2'b00}`, where seq is the sequential address. This also holds when adding 4 carries into bit 28.
- R3: Opcode 4 is taken exactly when `rs_val_i == rt_val_i`.
- R4: Opcode 5 is taken exactly when `rs_val_i != rt_val_i`.
- R5: Opcode 6 is taken exactly when `rs_val_i`, read as signed, is less than or equal to zero.
- R6: Opcode 7 is taken exactly when `rs_val_i`, read as signed, is greater than zero.
- R7: Opcode 1 takes its condition from `rt_sel_i`. A value of 0 tests signed `rs_val_i < 0` and a value of 1 tests signed `rs_val_i >= 0`. Any other value is never taken.
- R8: A taken conditional branch gives `next_pc_o` equal to the sequential address plus 4 times the sign-extended `imm_i`, wrapping modulo 2^32.
- R9: A conditional branch whose condition fails gives `next_pc_o` equal to the sequential address, with `taken_o` low.
- R10: Bits 1:0 of `next_pc_o` are always zero, whatever the value of `pc_i[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current instruction address |
| opcode_i | input | 6 | Decoded major opcode |
| rt_sel_i | input | 5 | Second register-select field; picks the sign test under opcode 1 |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| imm_i | input | 16 | Signed word offset for branches |
| jidx_i | input | 26 | Word index for jumps within the current region |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | High when the next address is not the sequential one |

## Verification
The bench targets the sign tests at the values 0, -1, 1, the most negative value and the most positive value. A design that confuses the strict and non-strict comparisons, or compares without sign, takes the wrong path at exactly those points. It drives opcode 1 with rt_sel values 0, 1 and other values; an incomplete decode of that field would take a branch on an unused value. It also places the PC at the last word of a 256 MB region and at the top of the address space. A jump that builds its region from the unincremented PC then lands in the wrong region, and a branch that drops the carry or sign-extends the offset wrongly misses its target. Finally, it supplies PCs with nonzero low bits, which a design that does not force word alignment passes through.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned OP_W     = 6;
  localparam int unsigned SEL_W    = 5;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned IDX_W    = 26;
  localparam int unsigned ALIGN_W  = 2;
  localparam int unsigned REGION_W = XLEN - IDX_W - ALIGN_W;

  typedef enum logic [OP_W-1:0] {
    OPC_ZCMP = 6'd1,
    OPC_JUMP = 6'd2,
    OPC_BEQ  = 6'd4,
    OPC_BNE  = 6'd5,
    OPC_BLEZ = 6'd6,
    OPC_BGTZ = 6'd7
  } opc_e;

  typedef enum logic [1:0] {
    XFER_SEQ,
    XFER_BRANCH,
    XFER_JUMP
  } xfer_e;

  typedef struct packed {
    logic eq;
    logic neg;
    logic zero;
  } cmp_flags_t;
endpackage

// File: rtl/npc_compare.sv
module npc_compare
  import npc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmp_flags_t   flags_o
);
  always_comb begin
    flags_o.eq   = (a_i == b_i);
    flags_o.neg  = a_i[W-1];
    flags_o.zero = ~|a_i;
  end
endmodule

// File: rtl/npc_decide.sv
module npc_decide
  import npc_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [SEL_W-1:0] rt_sel_i,
  input  cmp_flags_t       flags_i,
  output xfer_e            kind_o
);
  logic cond;
  logic is_branch;

  always_comb begin
    cond      = 1'b0;
    is_branch = 1'b1;
    kind_o    = XFER_SEQ;
    unique case (opcode_i)
      OPC_JUMP: is_branch = 1'b0;
      OPC_BEQ:  cond = flags_i.eq;
      OPC_BNE:  cond = ~flags_i.eq;
      OPC_BLEZ: cond = flags_i.neg | flags_i.zero;
      OPC_BGTZ: cond = ~flags_i.neg & ~flags_i.zero;
      OPC_ZCMP: begin
        if (rt_sel_i == SEL_W'(0))      cond = flags_i.neg;
        else if (rt_sel_i == SEL_W'(1)) cond = ~flags_i.neg;
        else                            cond = 1'b0;
      end
      default: is_branch = 1'b0;
    endcase
    if (opcode_i == OPC_JUMP) kind_o = XFER_JUMP;
    else if (is_branch && cond) kind_o = XFER_BRANCH;
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] imm_i,
  input  logic [IDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  branch_o,
  output logic [XLEN-1:0]  jump_o
);
  localparam int unsigned WORD_W = XLEN - ALIGN_W;

  logic [WORD_W-1:0] seq_word;
  logic [WORD_W-1:0] off_word;

  always_comb begin
    seq_word = pc_i[XLEN-1:ALIGN_W] + WORD_W'(1);
    off_word = WORD_W'(signed'(imm_i));
    seq_o    = {seq_word, {ALIGN_W{1'b0}}};
    branch_o = {seq_word + off_word, {ALIGN_W{1'b0}}};
    jump_o   = {seq_word[WORD_W-1 -: REGION_W], jidx_i, {ALIGN_W{1'b0}}};
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic [31:0] pc_i,
  input  logic [5:0]  opcode_i,
  input  logic [4:0]  rt_sel_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  input  logic [15:0] imm_i,
  input  logic [25:0] jidx_i,
  output logic [31:0] next_pc_o,
  output logic        taken_o
);
  cmp_flags_t      flags;
  xfer_e           kind;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jmp_pc;

  npc_compare #(.W(XLEN)) u_cmp (
    .a_i     (rs_val_i),
    .b_i     (rt_val_i),
    .flags_o (flags)
  );

  npc_decide u_dec (
    .opcode_i (opcode_i),
    .rt_sel_i (rt_sel_i),
    .flags_i  (flags),
    .kind_o   (kind)
  );

  npc_target u_tgt (
    .pc_i     (pc_i),
    .imm_i    (imm_i),
    .jidx_i   (jidx_i),
    .seq_o    (seq_pc),
    .branch_o (br_pc),
    .jump_o   (jmp_pc)
  );

  always_comb begin
    unique case (kind)
      XFER_JUMP:   next_pc_o = jmp_pc;
      XFER_BRANCH: next_pc_o = br_pc;
      default:     next_pc_o = seq_pc;
    endcase
    taken_o = (kind != XFER_SEQ);
  end

  logic [XLEN-1:0] chk_seq;
  logic            chk_known;
  always_comb begin
    chk_seq   = pc_i + 32'd4;
    chk_known = (opcode_i inside {6'd1, 6'd2, 6'd4, 6'd5, 6'd6, 6'd7});
    AST_ALIGNED_NEXT: assert (next_pc_o[1:0] == 2'b00) else $error("next pc misaligned"); // R10
    AST_UNKNOWN_FALLS: assert (chk_known || (!taken_o && next_pc_o[31:2] == chk_seq[31:2])) else $error("unknown opcode redirected"); // R1
    AST_JUMP_REGION: assert (opcode_i != 6'd2 || (taken_o && next_pc_o[31:28] == chk_seq[31:28] && next_pc_o[27:2] == jidx_i)) else $error("jump target wrong"); // R2
    AST_IDLE_SEQUENTIAL: assert (taken_o || next_pc_o[31:2] == chk_seq[31:2]) else $error("not-taken path not sequential"); // R9
    AST_EQ_NE_EXCLUSIVE: assert (!(opcode_i == 6'd4 && taken_o && rs_val_i != rt_val_i)) else $error("equality branch taken on mismatch"); // R3
  end
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk;
  logic [31:0] pc_i, rs_val_i, rt_val_i;
  logic [5:0]  opcode_i;
  logic [4:0]  rt_sel_i;
  logic [15:0] imm_i;
  logic [25:0] jidx_i;
  logic [31:0] next_pc_o;
  logic        taken_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  npc_unit dut (
    .pc_i(pc_i), .opcode_i(opcode_i), .rt_sel_i(rt_sel_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .imm_i(imm_i),
    .jidx_i(jidx_i), .next_pc_o(next_pc_o), .taken_o(taken_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic bit model_taken(input int op, input int sel,
                                     input logic [31:0] a, input logic [31:0] b);
    int sa;
    sa = $signed(a);
    case (op)
      2: return 1;
      4: return a == b;
      5: return a != b;
      6: return sa <= 0;
      7: return sa > 0;
      1: return (sel == 0) ? (sa < 0) : (sel == 1) ? (sa >= 0) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_next(input int op, input bit tk,
      input logic [31:0] pc, input logic [15:0] off, input logic [25:0] idx);
    longint unsigned base;
    longint signed   disp;
    base = ({32'd0, pc} & 64'hFFFF_FFFC) + 4;
    base = base & 64'hFFFF_FFFF;
    if (op == 2) return {base[31:28], idx, 2'b00};
    if (!tk) return base[31:0];
    disp = longint'($signed(off)) * 4;
    return 32'(longint'(base) + disp);
  endfunction

  task automatic check(input string tag);
    logic [31:0] en;
    bit et;
    et = model_taken(int'(opcode_i), int'(rt_sel_i), rs_val_i, rt_val_i);
    en = model_next(int'(opcode_i), et, pc_i, imm_i, jidx_i);
    checks++;
    if (taken_o !== et) begin
      fails++;
      $display("FAIL %s taken: actual %0b expected %0b (op %0d)", tag, taken_o, et, opcode_i);
    end
    checks++;
    if (next_pc_o !== en) begin
      fails++;
      $display("FAIL %s next_pc: actual %h expected %h (op %0d pc %h)", tag, next_pc_o, en, opcode_i, pc_i);
    end
  endtask

  task automatic apply(input string tag, input logic [5:0] op, input logic [4:0] sel,
                       input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] off, input logic [25:0] idx);
    @(posedge clk);
    opcode_i = op; rt_sel_i = sel; pc_i = pc; rs_val_i = a; rt_val_i = b;
    imm_i = off; jidx_i = idx;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    pc_i = 0; opcode_i = 0; rt_sel_i = 0; rs_val_i = 0; rt_val_i = 0; imm_i = 0; jidx_i = 0;
    @(negedge clk);
    check("R1 initial");
    apply("R1 op0",   6'd0,  5'd0, 32'h0000_1000, 32'd5, 32'd5, 16'h0010, 26'h1);
    apply("R1 op3",   6'd3,  5'd0, 32'h0000_2000, 32'd0, 32'd0, 16'h0010, 26'h1);
    apply("R1 op8",   6'd8,  5'd1, 32'hFFFF_FFFC, 32'd0, 32'd0, 16'h0010, 26'h1);
    apply("R2 jump",  6'd2,  5'd0, 32'h4000_0100, 0, 0, 0, 26'h3FF_FFFF);
    apply("R2 carry", 6'd2,  5'd0, 32'h0FFF_FFFC, 0, 0, 0, 26'h000_0040);
    apply("R2 wrap",  6'd2,  5'd0, 32'hFFFF_FFFC, 0, 0, 0, 26'h123_4567);
    apply("R3 eq",    6'd4,  5'd0, 32'h0000_0100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0003, 0);
    apply("R3 ne",    6'd4,  5'd0, 32'h0000_0100, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 16'h0003, 0);
    apply("R4 ne",    6'd5,  5'd0, 32'h0000_0100, 32'h8000_0000, 32'h0, 16'hFFFF, 0);
    apply("R4 eq",    6'd5,  5'd0, 32'h0000_0100, 32'h7, 32'h7, 16'hFFFF, 0);
    apply("R5 zero",  6'd6,  5'd0, 32'h0000_0200, 32'h0, 0, 16'h8000, 0);
    apply("R5 neg",   6'd6,  5'd0, 32'h0000_0200, 32'h8000_0000, 0, 16'h7FFF, 0);
    apply("R5 one",   6'd6,  5'd0, 32'h0000_0200, 32'h1, 0, 16'h7FFF, 0);
    apply("R6 zero",  6'd7,  5'd0, 32'h0000_0200, 32'h0, 0, 16'h0004, 0);
    apply("R6 max",   6'd7,  5'd0, 32'h0000_0200, 32'h7FFF_FFFF, 0, 16'h0004, 0);
    apply("R6 m1",    6'd7,  5'd0, 32'h0000_0200, 32'hFFFF_FFFF, 0, 16'h0004, 0);
    apply("R7 lt m1", 6'd1,  5'd0, 32'h0000_0300, 32'hFFFF_FFFF, 0, 16'hFFFE, 0);
    apply("R7 lt 0",  6'd1,  5'd0, 32'h0000_0300, 32'h0, 0, 16'hFFFE, 0);
    apply("R7 ge 0",  6'd1,  5'd1, 32'h0000_0300, 32'h0, 0, 16'h0020, 0);
    apply("R7 ge m",  6'd1,  5'd1, 32'h0000_0300, 32'h8000_0000, 0, 16'h0020, 0);
    apply("R7 sel2",  6'd1,  5'd2, 32'h0000_0300, 32'hFFFF_FFFF, 0, 16'h0020, 0);
    apply("R7 sel17", 6'd1,  5'd17, 32'h0000_0300, 32'h5, 0, 16'h0020, 0);
    apply("R8 wrapup", 6'd4, 5'd0, 32'hFFFF_FFF8, 1, 1, 16'h0004, 0);
    apply("R8 wrapdn", 6'd4, 5'd0, 32'h0000_0000, 1, 1, 16'h8000, 0);
    apply("R9 fail",  6'd7,  5'd0, 32'h0000_0400, 32'hFFFF_FF00, 0, 16'h0100, 0);
    apply("R10 lowbits", 6'd0, 5'd0, 32'h0000_0503, 0, 0, 0, 0);
    apply("R10 lowbr", 6'd4, 5'd0, 32'h0000_0502, 3, 3, 16'h0002, 0);
    apply("R10 lowj",  6'd2, 5'd0, 32'h1234_5677, 0, 0, 0, 26'h2AA_AAAA);
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  op;
      logic [31:0] a, b;
      int pick;
      pick = $urandom_range(0, 9);
      op = (pick < 8) ? 6'(pick) : 6'($urandom_range(8, 63));
      a = $urandom;
      case ($urandom_range(0, 4))
        0: a = 0;
        1: a = 32'hFFFF_FFFF;
        2: a = 32'h8000_0000;
        default: ;
      endcase
      b = ($urandom_range(0, 1) == 1) ? a : 32'($urandom);
      apply("R8 random", op, 5'($urandom_range(0, 3)), 32'($urandom), a, b,
            16'($urandom), 26'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule